// File: doc/BRIEF.md
# Bus Traffic Performance Monitor

This block watches the read and write data channels of one bus port and counts traffic for software. It has one cycle counter and four event counters, numbered 0 to 3. Each event counter is told by its own event-type register whether to count read data beats, write data beats or both. A beat is one cycle in which a channel's valid and ready are both high. Counter 3 is wider than the others. It is read as a low word and a high word, and it accepts one extra event code that counts both channels together.

Software reaches the block through a zero-wait APB-style register port. It picks counters with write-1-to-set and write-1-to-clear enable registers. It zeroes the counters and starts counting with a single control write, and it freezes everything by clearing the global enable so that it can read a consistent snapshot. A counter that wraps raises a flag. The single interrupt output is high while any flag is set and its interrupt enable is set.

Top module: `bpm_top`

## Requirements
- R1: After reset every register reads zero, every counter reads zero and `irq` is low.
- R2: Register reads and writes complete in the access phase with `pready` high. Offsets are word aligned. A read of any offset not listed here returns zero. The offsets are: control 0x00, enable-set 0x04, enable-clear 0x08, interrupt-enable-set 0x0C, interrupt-enable-clear 0x10, flags 0x14, cycle count 0x18, event-type 0x20/0x24/0x28/0x2C for counters 0..3, counts 0x30/0x34/0x38 for counters 0..2, counter 3 low word 0x3C, counter 3 high word 0x40.
- R3: Counter enables use one mask in which bits 3:0 select event counters 0..3 and bit 4 selects the cycle counter. Writing 1s to 0x04 sets mask bits and writing 1s to 0x08 clears them. Both offsets read back the current mask.
- R4: The cycle counter adds 1 on every clock while the global enable (control bit 0) and its mask bit are set and the start mode is manual.
- R5: An event-type field occupies bits 2:0. Code 0 counts nothing, code 1 counts read beats, code 2 counts write beats and code 3 counts both, adding 2 when both beats fall in the same cycle. Codes 4 to 7 count nothing on counters 0 to 2. Writing 0 returns a counter to counting nothing.
- R6: Counter 3 is 40 bits wide. Its bits 31:0 read at 0x3C and its bits 39:32 read in bits 7:0 of 0x40. On counter 3, code 4 counts read and write beats combined.
- R7: Control bit 1 zeroes the event counters and control bit 2 zeroes the cycle counter. Both bits clear themselves one cycle after the write, and during that cycle the zeroing has priority over counting. Writing 0x07 zeroes the counters, and counting starts on the following cycle.
- R8: While the global enable is clear, no counter changes.
- R9: The start-mode field is control bits 5:4. Only value 0 (manual) lets the counters run. Any other value holds them.
- R10: A counter that wraps from its top value through zero sets its bit in the flag register, using the same bit layout as the mask. Writing 1s to 0x14 clears flag bits. A wrap in the same cycle as a clear wins.
- R11: `irq` is high exactly while some flag bit and the same interrupt-enable bit are both set. Interrupt-enable bits are set at 0x0C and cleared at 0x10, and both offsets read back the enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Register port write strobe |
| paddr | input | 8 | Register byte offset |
| pwdata | input | 32 | Register write data |
| prdata | output | 32 | Register read data |
| pready | output | 1 | Always high (no wait states) |
| rd_valid | input | 1 | Monitored read data valid |
| rd_ready | input | 1 | Monitored read data ready |
| wr_valid | input | 1 | Monitored write data valid |
| wr_ready | input | 1 | Monitored write data ready |
| irq | output | 1 | Overflow interrupt |

## Verification
A register write takes effect at the clock edge of its access phase. The counter zeroing requested by that write happens at the next edge, and beats driven before a clock edge are counted at that edge. The bench therefore gives the cycle counter a count of the run length plus two: one edge after the zeroing and one for the closing write. Beats are held low from the start of the enabling write through the zeroing edge. Counts, flags and `irq` are read only after the freezing write has landed, because the read data and the interrupt are combinational views of registered state. Wrap behaviour is checked by building the bench instance with a narrower counter width.

// File: rtl/bpm_pkg.sv
// Shared constants for the bus traffic performance monitor.
// Assumes: 8-bit byte offsets, 32-bit register data, exactly four event counters.
package bpm_pkg;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned NUM_EV  = 4;
    localparam int unsigned MASK_W  = NUM_EV + 1;   // bit NUM_EV is the cycle counter
    localparam int unsigned CYC_BIT = NUM_EV;
    localparam int unsigned SEL_W   = 3;

    localparam logic [ADDR_W-1:0] OFF_CTRL    = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_EN_SET  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_EN_CLR  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_IE_SET  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_IE_CLR  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_FLAG    = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_CYC     = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_SEL0    = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_CNT0    = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_WIDE_LO = 8'h3C;
    localparam logic [ADDR_W-1:0] OFF_WIDE_HI = 8'h40;

    typedef enum logic [SEL_W-1:0] {
        EV_NONE = 3'd0,
        EV_RD   = 3'd1,
        EV_WR   = 3'd2,
        EV_RW   = 3'd3,
        EV_COMB = 3'd4
    } bpm_ev_e;

    localparam logic [1:0] MODE_MANUAL = 2'd0;
endpackage

// File: rtl/bpm_counter.sv
// One monitor counter: cycle counter or beat counter, chosen by IS_CYCLE.
// Assumes: clr outranks run; wrap pulses for the cycle in which the count
// carries out of its top bit.
module bpm_counter
    import bpm_pkg::*;
#(
    parameter int unsigned W          = 32,
    parameter bit          IS_CYCLE   = 1'b0,
    parameter bit          ALLOW_COMB = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 run,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 rd_beat,
    input  logic                 wr_beat,
    output logic [W-1:0]         count,
    output logic                 wrap
);
    logic [1:0] inc;
    logic [W:0] sum;

    generate
        if (IS_CYCLE) begin : g_cyc
            logic unused_cyc;
            assign unused_cyc = ^{sel, rd_beat, wr_beat};
            // Purpose: a cycle counter advances by one per clock.
            always_comb inc = 2'd1;
        end else begin : g_ev
            // Purpose: decode the event type into the step for this cycle.
            always_comb begin
                case (sel)
                    EV_RD:   inc = {1'b0, rd_beat};
                    EV_WR:   inc = {1'b0, wr_beat};
                    EV_RW:   inc = {1'b0, rd_beat} + {1'b0, wr_beat};
                    EV_COMB: inc = ALLOW_COMB ? ({1'b0, rd_beat} + {1'b0, wr_beat}) : 2'd0;
                    default: inc = 2'd0;
                endcase
            end
        end
    endgenerate

    // Purpose: next count with carry-out for wrap detection.
    always_comb begin
        sum  = {1'b0, count} + (W+1)'(inc);
        wrap = run && !clr && sum[W];
    end

    // Purpose: hold, zero or advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (clr)    count <= '0;
        else if (run)    count <= sum[W-1:0];
    end

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(count));
    p_step_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |=> (W'(count - $past(count)) <= W'(2)));
endmodule

// File: rtl/bpm_regs.sv
// Register file and read mux of the monitor.
// Assumes: zero-wait register port, writes land in the access phase,
// reset bits self-clear, flags set on wrap with set winning over clear.
module bpm_regs
    import bpm_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned WIDE_W = 40
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        psel,
    input  logic                        penable,
    input  logic                        pwrite,
    input  logic [ADDR_W-1:0]           paddr,
    input  logic [DATA_W-1:0]           pwdata,
    output logic [DATA_W-1:0]           prdata,
    input  logic [CNT_W-1:0]            cyc_cnt,
    input  logic [CNT_W-1:0]            ev_cnt [NUM_EV-1],
    input  logic [WIDE_W-1:0]           wide_cnt,
    input  logic [MASK_W-1:0]           wrap,
    output logic [MASK_W-1:0]           run_mask,
    output logic                        clr_ev,
    output logic                        clr_cyc,
    output logic [SEL_W-1:0]            sel [NUM_EV],
    output logic                        irq
);
    localparam int unsigned HI_W = WIDE_W - 32;

    logic              wr_en;
    logic              ena;
    logic [1:0]        mode;
    logic [MASK_W-1:0] en_mask;
    logic [MASK_W-1:0] ie_mask;
    logic [MASK_W-1:0] flags;
    logic [MASK_W-1:0] wbits;
    logic              unused_wdata;

    assign wr_en        = psel && penable && pwrite;
    assign wbits        = pwdata[MASK_W-1:0];
    assign unused_wdata = ^pwdata[DATA_W-1:6];

    // Purpose: control register with self-clearing reset bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena <= 1'b0; mode <= MODE_MANUAL; clr_ev <= 1'b0; clr_cyc <= 1'b0;
        end else begin
            clr_ev  <= 1'b0;
            clr_cyc <= 1'b0;
            if (wr_en && paddr == OFF_CTRL) begin
                ena     <= pwdata[0];
                clr_ev  <= pwdata[1];
                clr_cyc <= pwdata[2];
                mode    <= pwdata[5:4];
            end
        end
    end

    // Purpose: set/clear counter enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)                             en_mask <= '0;
        else if (wr_en && paddr == OFF_EN_SET)  en_mask <= en_mask | wbits;
        else if (wr_en && paddr == OFF_EN_CLR)  en_mask <= en_mask & ~wbits;
    end

    // Purpose: set/clear interrupt enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ie_mask <= '0;
        else if (wr_en && paddr == OFF_IE_SET)  ie_mask <= ie_mask | wbits;
        else if (wr_en && paddr == OFF_IE_CLR)  ie_mask <= ie_mask & ~wbits;
    end

    // Purpose: wrap flags, write-1-to-clear, wrap wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~((wr_en && paddr == OFF_FLAG) ? wbits : '0)) | wrap;
    end

    generate
        for (genvar i = 0; i < NUM_EV; i++) begin : g_sel
            // Purpose: event-type register of counter i.
            always_ff @(posedge clk) begin
                if (!rst_n) sel[i] <= EV_NONE;
                else if (wr_en && paddr == OFF_SEL0 + ADDR_W'(4*i)) sel[i] <= pwdata[SEL_W-1:0];
            end
        end
    endgenerate

    assign run_mask = (ena && mode == MODE_MANUAL) ? en_mask : '0;
    assign irq      = |(flags & ie_mask);

    // Purpose: read data mux; unmapped offsets and writes return zero.
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (paddr)
                OFF_CTRL:             prdata = {26'd0, mode, 1'b0, clr_cyc, clr_ev, ena};
                OFF_EN_SET, OFF_EN_CLR: prdata = DATA_W'(en_mask);
                OFF_IE_SET, OFF_IE_CLR: prdata = DATA_W'(ie_mask);
                OFF_FLAG:             prdata = DATA_W'(flags);
                OFF_CYC:              prdata = DATA_W'(cyc_cnt);
                OFF_SEL0:             prdata = DATA_W'(sel[0]);
                OFF_SEL0 + 8'h04:     prdata = DATA_W'(sel[1]);
                OFF_SEL0 + 8'h08:     prdata = DATA_W'(sel[2]);
                OFF_SEL0 + 8'h0C:     prdata = DATA_W'(sel[3]);
                OFF_CNT0:             prdata = DATA_W'(ev_cnt[0]);
                OFF_CNT0 + 8'h04:     prdata = DATA_W'(ev_cnt[1]);
                OFF_CNT0 + 8'h08:     prdata = DATA_W'(ev_cnt[2]);
                OFF_WIDE_LO:          prdata = wide_cnt[31:0];
                OFF_WIDE_HI:          prdata = DATA_W'(wide_cnt[WIDE_W-1:32]);
                default:              prdata = '0;
            endcase
        end
    end

    p_selfclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ev && !(wr_en && paddr == OFF_CTRL)) |=> !clr_ev);
    p_wrap_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap != '0) |=> ((flags & $past(wrap)) == $past(wrap)));
    p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_MANUAL) |-> (run_mask == '0));
    p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && paddr > OFF_WIDE_HI) |-> (prdata == '0));
    initial assert (HI_W >= 1 && HI_W <= 32);
endmodule

// File: rtl/bpm_top.sv
// Bus traffic performance monitor top: register file, one cycle counter,
// four event counters (counter 3 wide, with the combined event code).
// Assumes: beat inputs are synchronous to clk; CNT_W <= 32 < WIDE_W <= 64.
module bpm_top
    import bpm_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned WIDE_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [7:0]        paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    input  logic              rd_valid,
    input  logic              rd_ready,
    input  logic              wr_valid,
    input  logic              wr_ready,
    output logic              irq
);
    logic              rd_beat, wr_beat;
    logic [CNT_W-1:0]  cyc_cnt;
    logic [CNT_W-1:0]  ev_cnt [NUM_EV-1];
    logic [WIDE_W-1:0] wide_cnt;
    logic [MASK_W-1:0] wrap;
    logic [MASK_W-1:0] run_mask;
    logic              clr_ev, clr_cyc;
    logic [SEL_W-1:0]  sel [NUM_EV];

    assign rd_beat = rd_valid && rd_ready;
    assign wr_beat = wr_valid && wr_ready;
    assign pready  = 1'b1;

    bpm_regs #(.CNT_W(CNT_W), .WIDE_W(WIDE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .cyc_cnt(cyc_cnt), .ev_cnt(ev_cnt), .wide_cnt(wide_cnt), .wrap(wrap),
        .run_mask(run_mask), .clr_ev(clr_ev), .clr_cyc(clr_cyc), .sel(sel), .irq(irq)
    );

    bpm_counter #(.W(CNT_W), .IS_CYCLE(1'b1), .ALLOW_COMB(1'b0)) u_cyc (
        .clk(clk), .rst_n(rst_n), .clr(clr_cyc), .run(run_mask[CYC_BIT]),
        .sel(EV_NONE), .rd_beat(1'b0), .wr_beat(1'b0),
        .count(cyc_cnt), .wrap(wrap[CYC_BIT])
    );

    generate
        for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
            if (i == NUM_EV - 1) begin : g_wide
                bpm_counter #(.W(WIDE_W), .IS_CYCLE(1'b0), .ALLOW_COMB(1'b1)) u_cnt (
                    .clk(clk), .rst_n(rst_n), .clr(clr_ev), .run(run_mask[i]),
                    .sel(sel[i]), .rd_beat(rd_beat), .wr_beat(wr_beat),
                    .count(wide_cnt), .wrap(wrap[i])
                );
            end else begin : g_narrow
                bpm_counter #(.W(CNT_W), .IS_CYCLE(1'b0), .ALLOW_COMB(1'b0)) u_cnt (
                    .clk(clk), .rst_n(rst_n), .clr(clr_ev), .run(run_mask[i]),
                    .sel(sel[i]), .rd_beat(rd_beat), .wr_beat(wr_beat),
                    .count(ev_cnt[i]), .wrap(wrap[i])
                );
            end
        end
    endgenerate

    p_irq_low_r1: assert property (@(posedge clk) $fell(rst_n) |=> !irq);
endmodule

// File: tb/tb_bpm_top.sv
module tb_bpm_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic pready;
    logic rd_valid = 0, rd_ready = 0, wr_valid = 0, wr_ready = 0;
    logic irq;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bpm_top #(.CNT_W(CW), .WIDE_W(40)) dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .irq(irq)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
        rd_valid = 0; wr_valid = 0;
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1; #1;
        if (pready !== 1'b1) begin checks++; errors++; $display("FAIL R2 pready actual=%0d expected=1", pready); end
        d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    function automatic int beat_val(int idx, logic [2:0] code, bit r, bit w);
        case (code)
            3'd1: return int'(r);
            3'd2: return int'(w);
            3'd3: return int'(r) + int'(w);
            3'd4: return (idx == 3) ? int'(r) + int'(w) : 0;
            default: return 0;
        endcase
    endfunction

    task automatic run_window(input logic [4:0] mask, input logic [1:0] mode, input int n);
        logic [31:0] d;
        logic [2:0] codes [4];
        longint exp [4];
        logic [31:0] snap0, snap1;
        apb_write(8'h08, 32'h1F);
        apb_write(8'h04, 32'(mask));
        apb_read(8'h04, d); check("R3 en_set readback", d, mask);
        apb_read(8'h08, d); check("R3 en_clr readback", d, mask);
        for (int i = 0; i < 4; i++) begin
            codes[i] = 3'($urandom_range(0, 7));
            exp[i] = 0;
            apb_write(8'h20 + 8'(4*i), 32'(codes[i]));
        end
        apb_write(8'h00, {26'd0, mode, 4'h7});
        @(negedge clk);
        for (int k = 0; k < n; k++) begin
            bit r, w;
            rd_valid = 1'($urandom); rd_ready = 1'($urandom);
            wr_valid = 1'($urandom); wr_ready = 1'($urandom);
            r = rd_valid && rd_ready; w = wr_valid && wr_ready;
            for (int i = 0; i < 4; i++)
                if (mask[i]) exp[i] += beat_val(i, codes[i], r, w);
            @(negedge clk);
        end
        apb_write(8'h00, {26'd0, mode, 4'h0});
        for (int i = 0; i < 4; i++) if (mode != 0) exp[i] = 0;
        apb_read(8'h18, d);
        check(mode != 0 ? "R9 cycle held" : "R4 cycle count", d, (mask[4] && mode == 0) ? n + 2 : 0);
        for (int i = 0; i < 3; i++) begin
            apb_read(8'h30 + 8'(4*i), d);
            check(mode != 0 ? "R9 event held" : "R5 event count", d, exp[i]);
        end
        apb_read(8'h3C, d); check("R6 wide low word", d, exp[3]);
        apb_read(8'h40, d); check("R6 wide high word", d, 0);
        apb_read(8'h30, snap0);
        for (int k = 0; k < 16; k++) begin
            rd_valid = 1; rd_ready = 1; wr_valid = 1; wr_ready = 1;
            @(negedge clk);
        end
        rd_valid = 0; wr_valid = 0;
        apb_read(8'h30, snap1); check("R8 frozen counter", snap1, snap0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq after reset", irq, 0);
        apb_read(8'h00, d); check("R1 ctrl reset", d, 0);
        apb_read(8'h04, d); check("R1 enable reset", d, 0);
        apb_read(8'h14, d); check("R1 flag reset", d, 0);
        apb_read(8'h18, d); check("R1 cycle reset", d, 0);
        apb_read(8'h3C, d); check("R1 wide reset", d, 0);
        // R2 unmapped
        apb_write(8'hFC, 32'hFFFF_FFFF);
        apb_read(8'hFC, d); check("R2 unmapped read", d, 0);
        apb_read(8'h44, d); check("R2 unmapped read", d, 0);
        // R5 / R6 directed codes
        apb_write(8'h2C, 32'd4);
        apb_read(8'h2C, d); check("R6 combined code stored", d, 4);
        // random windows, R4 R5 R6 R7 R8
        for (int t = 0; t < 6; t++)
            run_window(5'($urandom_range(0, 31)) | 5'h10, 2'd0, 40 + $urandom_range(0, 200));
        run_window(5'h1F, 2'd2, 60);
        // R3 partial clear
        apb_write(8'h08, 32'h05);
        apb_read(8'h04, d); check("R3 partial clear", d, 32'h1A);
        // R10 / R11 wrap with narrow counters
        apb_write(8'h08, 32'h1F);
        apb_write(8'h04, 32'h11);
        apb_write(8'h20, 32'd3);
        apb_write(8'h0C, 32'h10);
        apb_write(8'h00, 32'h7);
        @(negedge clk);
        for (int k = 0; k < 1100; k++) begin
            rd_valid = 1; rd_ready = 1; wr_valid = 1; wr_ready = 1;
            @(negedge clk);
        end
        apb_write(8'h00, 32'h0);
        apb_read(8'h30, d); check("R10 counter0 after wrap", d, (2*1100) % (1 << CW));
        apb_read(8'h18, d); check("R10 cycle after wrap", d, 1102 % (1 << CW));
        apb_read(8'h14, d); check("R10 flags set", d, 32'h11);
        check("R11 irq on cycle flag", irq, 1);
        apb_write(8'h14, 32'h10);
        apb_read(8'h14, d); check("R10 flag w1c", d, 32'h01);
        check("R11 irq gated by enable", irq, 0);
        apb_write(8'h0C, 32'h01);
        check("R11 irq counter0 flag", irq, 1);
        apb_write(8'h10, 32'h01);
        check("R11 irq after enable clear", irq, 0);
        apb_read(8'h10, d); check("R11 enable readback", d, 32'h10);
        // R7 zero without enabling
        apb_write(8'h00, 32'h6);
        apb_read(8'h30, d); check("R7 event zeroed", d, 0);
        apb_read(8'h18, d); check("R7 cycle zeroed", d, 0);
        apb_read(8'h00, d); check("R7 reset bits self-clear", d, 0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule